// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two byte-wide buses, A and B, through one path for each direction. Each path has a storage register with its own clock. It also has a select that forwards either the live value from the opposite bus or the stored value, and an output enable with its own polarity. Each register loads on every rising edge of its clock. The selects and enables never stop or gate that load, so a bus can be sampled while neither direction drives.

Each bus is split into an input, an output value and a drive-enable. A pad ring or test environment can then resolve the pins as it needs. When both directions are enabled in live mode, each bus is driven with the value read from the other. The pair of buses then forms a loop that keeps its last value after every external driver lets go.

Top module: `bidirRegXcvr`

## Requirements
- R1: An active-low `rstN` clears both storage registers to 0x00 at once, without waiting for a clock edge, and holds them there while it stays low.
- R2: The A-side register loads `aIn` on every rising edge of `clkAB`, whatever the levels of `oeAb`, `oeBaN`, `selAb` and `selBa`. Edges of `clkBA` leave it unchanged.
- R3: The B-side register loads `bIn` on every rising edge of `clkBA`, whatever the levels of the enables and selects. Edges of `clkAB` leave it unchanged.
- R4: With `selAb` = 0, `bOut` equals the present `aIn`. With `selAb` = 1, `bOut` equals the A-side register.
- R5: With `selBa` = 0, `aOut` equals the present `bIn`. With `selBa` = 1, `aOut` equals the B-side register.
- R6: `bOe` is 1 exactly when `oeAb` is 1 (active high). While it is 0, the block does not drive bus B.
- R7: `aOe` is 1 exactly when `oeBaN` is 0 (active low). While it is 1, the block does not drive bus A.
- R8: With both selects at 0, `oeAb` = 1 and `oeBaN` = 0, a value first placed on bus A by an outside driver stays on both buses after that driver is released.
- R9: If a select changes while its stored and live values are equal, the output it steers keeps that value throughout, with no intermediate value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkAB | input | 1 | Load clock of the A-side register (A-to-B path) |
| clkBA | input | 1 | Load clock of the B-side register (B-to-A path) |
| rstN | input | 1 | Asynchronous active-low clear of both registers |
| oeAb | input | 1 | Active-high drive enable for bus B |
| oeBaN | input | 1 | Active-low drive enable for bus A |
| selAb | input | 1 | 0: live A to B, 1: stored A to B |
| selBa | input | 1 | 0: live B to A, 1: stored B to A |
| aIn | input | 8 | Resolved value seen on bus A |
| aOut | output | 8 | Value the block places on bus A |
| aOe | output | 1 | Drive enable of bus A |
| bIn | input | 8 | Resolved value seen on bus B |
| bOut | output | 8 | Value the block places on bus B |
| bOe | output | 1 | Drive enable of bus B |

## Verification
First, all-zero, all-one, alternating and walking-one bytes are passed live in each direction. These patterns separate a swapped or stuck bit from a select that takes the wrong source. Next, both registers are loaded while both drivers are off and then put on the buses in stored mode. This separates a register that loads on every edge from one gated by an enable, and it exposes the swap that follows when each stored path feeds the other register. A pseudo-random run of controls and bytes, kept free of bus contention, is then compared against a reference model every cycle. Last, the bench holds a value on both buses after the outside driver lets go, switches a select between equal sources, and applies an asynchronous clear in mid-cycle.

// File: rtl/xcvrPkg.sv
`timescale 1ns/1ps
package xcvrPkg;

  // strobes passed from control to the datapath
  typedef struct packed {
    logic driveA;     // block drives bus A
    logic driveB;     // block drives bus B
    logic storedToA;  // B-side register steers bus A
    logic storedToB;  // A-side register steers bus B
  } xcvrStrobe_t;

  localparam int NUM_DIRS = 2;
  localparam int DIR_AB   = 0;
  localparam int DIR_BA   = 1;

endpackage

// File: rtl/xcvrCtrl.sv
`timescale 1ns/1ps
module xcvrCtrl
  import xcvrPkg::*;
#(
  parameter bit AB_OE_ACTIVE = 1'b1,  // level of oeAb that drives B
  parameter bit BA_OE_ACTIVE = 1'b0   // level of oeBaN that drives A
) (
  input  logic        oeAb,
  input  logic        oeBaN,
  input  logic        selAb,
  input  logic        selBa,
  output xcvrStrobe_t strobe
);

  always_comb begin
    strobe           = '0;
    strobe.driveB    = (oeAb == AB_OE_ACTIVE);
    strobe.driveA    = (oeBaN == BA_OE_ACTIVE);
    strobe.storedToB = selAb;
    strobe.storedToA = selBa;
  end

endmodule

// File: rtl/xcvrLane.sv
`timescale 1ns/1ps
module xcvrLane #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] srcIn,
  input  logic              pickStored,
  output logic [DATA_W-1:0] laneOut
);

  logic [DATA_W-1:0] storeQ;

  // loads on every edge; no enable term on purpose
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) storeQ <= '0;
    else       storeQ <= srcIn;
  end

  // plain two-input select, one level of logic per bit
  always_comb begin
    laneOut = pickStored ? storeQ : srcIn;
  end

  // R1
  clear_on_release_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> storeQ == '0);

  // R2 R3
  load_every_edge_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    $past(rstN) |-> storeQ == $past(srcIn));

endmodule

// File: rtl/bidirRegXcvr.sv
`timescale 1ns/1ps
module bidirRegXcvr
  import xcvrPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clkAB,
  input  logic              clkBA,
  input  logic              rstN,
  input  logic              oeAb,
  input  logic              oeBaN,
  input  logic              selAb,
  input  logic              selBa,
  input  logic [DATA_W-1:0] aIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aOe,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] bOut,
  output logic              bOe
);

  xcvrStrobe_t strobe;

  logic              laneClk  [NUM_DIRS];
  logic [DATA_W-1:0] laneSrc  [NUM_DIRS];
  logic              lanePick [NUM_DIRS];
  logic [DATA_W-1:0] laneOut  [NUM_DIRS];

  xcvrCtrl #(
    .AB_OE_ACTIVE(1'b1),
    .BA_OE_ACTIVE(1'b0)
  ) ctrl (
    .oeAb  (oeAb),
    .oeBaN (oeBaN),
    .selAb (selAb),
    .selBa (selBa),
    .strobe(strobe)
  );

  always_comb begin
    laneClk[DIR_AB]  = clkAB;
    laneSrc[DIR_AB]  = aIn;
    lanePick[DIR_AB] = strobe.storedToB;
    laneClk[DIR_BA]  = clkBA;
    laneSrc[DIR_BA]  = bIn;
    lanePick[DIR_BA] = strobe.storedToA;
  end

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_lane
    xcvrLane #(.DATA_W(DATA_W)) lane (
      .clk       (laneClk[d]),
      .rstN      (rstN),
      .srcIn     (laneSrc[d]),
      .pickStored(lanePick[d]),
      .laneOut   (laneOut[d])
    );
  end

  assign bOut = laneOut[DIR_AB];
  assign aOut = laneOut[DIR_BA];
  assign bOe  = strobe.driveB;
  assign aOe  = strobe.driveA;

  // R6
  b_release_chk: assert property (
    @(posedge clkAB) disable iff (!rstN)
    !oeAb |-> !bOe);

  // R7
  a_release_chk: assert property (
    @(posedge clkBA) disable iff (!rstN)
    oeBaN |-> !aOe);

  // R4
  ab_live_chk: assert property (
    @(posedge clkAB) disable iff (!rstN)
    !selAb |-> bOut == aIn);

  // R4
  ab_stored_chk: assert property (
    @(posedge clkAB) disable iff (!rstN)
    ($past(rstN) && selAb) |-> bOut == $past(aIn));

  // R5
  ba_live_chk: assert property (
    @(posedge clkBA) disable iff (!rstN)
    !selBa |-> aOut == bIn);

  // R5
  ba_stored_chk: assert property (
    @(posedge clkBA) disable iff (!rstN)
    ($past(rstN) && selBa) |-> aOut == $past(bIn));

endmodule

// File: tb/bidirRegXcvr_test.sv
`timescale 1ns/1ps
module bidirRegXcvr_test;

  localparam int W = 8;
  localparam realtime WDOG_NS = 8.0 * 200000.0;

  logic clkAB, clkBA, rstN;
  logic oeAb, oeBaN, selAb, selBa;
  logic [W-1:0] aNet, bNet, aOut, bOut;
  logic aOe, bOe;

  // outside drivers on the two buses
  logic         extAEn, extBEn;
  logic [W-1:0] extA, extB;

  // reference registers
  logic [W-1:0] mA, mB;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  bidirRegXcvr #(.DATA_W(W)) uut (
    .clkAB(clkAB), .clkBA(clkBA), .rstN(rstN),
    .oeAb(oeAb), .oeBaN(oeBaN), .selAb(selAb), .selBa(selBa),
    .aIn(aNet), .aOut(aOut), .aOe(aOe),
    .bIn(bNet), .bOut(bOut), .bOe(bOe)
  );

  initial begin
    clkAB = 1'b0;
    forever #4 clkAB = ~clkAB;
  end

  initial begin
    clkBA = 1'b0;
    #2;
    forever #4 clkBA = ~clkBA;
  end

  always @(posedge clkAB or negedge rstN)
    if (!rstN) mA <= '0; else mA <= aNet;

  always @(posedge clkBA or negedge rstN)
    if (!rstN) mB <= '0; else mB <= bNet;

  // resolve each bus: block driver, else outside driver, else keep last value
  task automatic settle();
    for (int i = 0; i < 4; i++) begin
      if (aOe)         aNet = aOut;
      else if (extAEn) aNet = extA;
      if (bOe)         bNet = bOut;
      else if (extBEn) bNet = extB;
      #0.1;
    end
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R6", {7'd0, bOe}, {7'd0, oeAb});
    check("R7", {7'd0, aOe}, {7'd0, ~oeBaN});
    check("R4", bOut, selAb ? mA : aNet);
    check("R5", aOut, selBa ? mB : bNet);
  endtask

  // stimulus set at the start of a cycle (t = 8k)
  task automatic tick();
    settle();
    @(posedge clkAB); settle();
    @(posedge clkBA); settle();
    #0.5;
    compareAll();
    @(negedge clkAB);
  endtask

  task automatic setCtl(logic oab, logic obaN, logic sab, logic sba);
    oeAb = oab; oeBaN = obaN; selAb = sab; selBa = sba;
  endtask

  initial begin
    #(WDOG_NS);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat [8];
    logic [31:0] lfsr;
    rstN = 1'b0;
    aNet = '0; bNet = '0;
    extAEn = 0; extBEn = 0; extA = '0; extB = '0;
    // R1: stored paths on both sides while clear is held
    setCtl(1, 0, 1, 1);
    tick(); tick();
    check("R1", bOut, 8'h00);
    check("R1", aOut, 8'h00);
    setCtl(0, 1, 0, 0);
    rstN = 1'b1;
    tick();

    pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'h55; pat[3] = 8'hAA;
    pat[4] = 8'h01; pat[5] = 8'h10; pat[6] = 8'h80; pat[7] = 8'h7E;

    // R4: live A to B
    setCtl(1, 1, 0, 0);
    extAEn = 1;
    foreach (pat[i]) begin
      extA = pat[i];
      tick();
      check("R4", bNet, pat[i]);
    end
    extAEn = 0;

    // R5: live B to A
    setCtl(0, 0, 0, 0);
    extBEn = 1;
    foreach (pat[i]) begin
      extB = pat[i];
      tick();
      check("R5", aNet, pat[i]);
    end

    // R2 R3: load while both drivers are off
    setCtl(0, 1, 1, 1);
    extAEn = 1; extBEn = 1; extA = 8'h3C; extB = 8'hC3;
    tick();
    extAEn = 0; extBEn = 0;
    setCtl(1, 0, 1, 1);
    settle();
    check("R2", bOut, 8'h3C);
    check("R3", aOut, 8'hC3);
    check("R6", {7'd0, bOe}, 8'h01);
    check("R7", {7'd0, aOe}, 8'h01);
    @(negedge clkAB);
    // stored paths now feed each other's registers: values swap
    tick(); tick(); tick();

    // R9: select change with equal stored and live values
    setCtl(0, 1, 0, 0);
    extAEn = 1; extA = 8'h69;
    tick();
    setCtl(1, 1, 0, 0);
    settle();
    check("R9", bOut, 8'h69);
    selAb = 1; #0.05;
    check("R9", bOut, 8'h69);
    selAb = 0; #0.05;
    check("R9", bOut, 8'h69);
    selAb = 1; #0.05;
    check("R9", bOut, 8'h69);
    @(negedge clkAB);
    tick();

    // R8: self-holding loop after the outside driver lets go
    setCtl(1, 1, 0, 0);
    extA = 8'h96;
    tick();
    setCtl(1, 0, 0, 0);
    tick();
    extAEn = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R8", aNet, 8'h96);
      check("R8", bNet, 8'h96);
    end

    // mixed run; outside drivers only on released buses
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 120; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      setCtl(lfsr[0], lfsr[1], lfsr[2], lfsr[3]);
      extA = lfsr[15:8]; extB = lfsr[23:16];
      extAEn = oeBaN && lfsr[4];
      extBEn = !oeAb && lfsr[5];
      tick();
    end
    extAEn = 0; extBEn = 0;

    // R1: clear lands at once, mid-cycle
    setCtl(0, 1, 1, 1);
    extAEn = 1; extBEn = 1; extA = 8'h11; extB = 8'h22;
    tick();
    extAEn = 0; extBEn = 0;
    setCtl(1, 0, 1, 1);
    settle();
    check("R2", bOut, 8'h11);
    check("R3", aOut, 8'h22);
    rstN = 1'b0;
    #0.1;
    check("R1", bOut, 8'h00);
    check("R1", aOut, 8'h00);
    @(negedge clkAB);
    tick();
    rstN = 1'b1;
    tick(); tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule